// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block produces the word address sequence for a four-beat burst access into a synchronous memory. An external address is captured when either of two active-low strobes is recognised: a processor strobe or a controller strobe. After that capture, the block walks the two lowest address bits through a wrap-around sequence while the upper bits stay unchanged. The memory array and the data path sit outside this block. They use the registered address and a valid flag that this block drives.

A static order input selects one of two beat orders. Low gives linear stepping, where each beat adds one modulo four. High gives interleaved stepping, where each beat is the start value XOR a beat index. An active-low advance input moves the burst forward by one beat. Holding advance high suspends the burst on its current address. Three chip enables qualify each capture: a primary active-low enable, an active-high enable and a second active-low enable. They are looked at only in capture cycles, never while a burst continues.

Top module: `sbag_top`

## Requirements
- R1: While `rst` is high, `addr_valid` goes low and `addr_out` goes to zero on the next clock edge.
- R2: If `proc_strobe_n` is low, `sel_n` is low, `sel_hi` is high and `sel_lo_n` is low at an edge, then after that edge `addr_out` equals the sampled `addr_in` and `addr_valid` is high.
- R3: A low `ctrl_strobe_n` with all three enables active loads `addr_in` in the same way when the processor strobe is not recognised.
- R4: When both strobes are low with the primary enable active, the block recognises only the processor strobe. It performs exactly one capture of `addr_in`, and the beat index restarts at zero.
- R5: A recognised strobe with `sel_hi` low or `sel_lo_n` high deselects the block: `addr_valid` goes low and `addr_out` keeps its value. While `addr_valid` is low, advance has no effect.
- R6: While `sel_n` is high, the processor strobe is ignored. With no controller strobe, the cycle acts as a plain hold or advance. A controller strobe in that cycle deselects the block.
- R7: With `order_mode` = 0, each advance sets the low two bits to (start + k) mod 4 for beat k. For example, a start of 01 gives 01, 10, 11, 00.
- R8: With `order_mode` = 1, beat k carries start XOR k in the low two bits. For example, a start of 10 gives 10, 11, 00, 01.
- R9: The fourth advance after a capture returns the low bits to the captured start value, in either order.
- R10: In a cycle with no recognised strobe and `advance_n` high, `addr_out` and `addr_valid` keep their values (suspend).
- R11: Changes on the chip enables during a burst, with no strobe, do not alter the advance sequence.
- R12: A recognised strobe in the middle of a burst captures the new address and abandons the old burst.
- R13: Bits above the two burst bits change only on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| proc_strobe_n | input | 1 | Processor address strobe, active low, priority strobe |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| sel_n | input | 1 | Primary chip enable, active low; also gates the processor strobe |
| sel_hi | input | 1 | Chip enable, active high |
| sel_lo_n | input | 1 | Chip enable, active low |
| advance_n | input | 1 | Advance to the next beat, active low |
| order_mode | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_in | input | ADDR_W | External word address |
| addr_out | output | ADDR_W | Registered current word address |
| addr_valid | output | 1 | Registered flag: a selected address is held |

## Verification
The bench builds the block with ADDR_W = 12 and BURST_W = 2. This keeps the burst at four beats, so every wrap happens within a handful of advances. It also keeps enough upper bits to show that a carry out of the burst bits never reaches them. The reference model tracks start value and beat index as integers. It drives both order settings, both strobes alone and together, and each enable inactive in turn, and it reloads in the middle of a burst. It compares address and flag after every edge.

// File: rtl/sbag_pkg.sv
package sbag_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_DESEL = 2'd3
  } sbag_act_e;
endpackage

// File: rtl/sbag_arbiter.sv
module sbag_arbiter
  import sbag_pkg::*;
(
  input  logic      proc_strobe_n,
  input  logic      ctrl_strobe_n,
  input  logic      sel_n,
  input  logic      sel_hi,
  input  logic      sel_lo_n,
  input  logic      advance_n,
  input  logic      valid_q,
  output sbag_act_e act
);
  logic proc_seen;
  logic any_strobe;
  logic all_enabled;

  always_comb begin
    // processor strobe only counts with the primary enable low
    proc_seen   = !proc_strobe_n && !sel_n;
    any_strobe  = proc_seen || !ctrl_strobe_n;
    all_enabled = !sel_n && sel_hi && !sel_lo_n;
    if (any_strobe)
      act = all_enabled ? ACT_LOAD : ACT_DESEL;
    else if (valid_q && !advance_n)
      act = ACT_STEP;
    else
      act = ACT_HOLD;
  end
endmodule

// File: rtl/sbag_burst_seq.sv
module sbag_burst_seq
  import sbag_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  sbag_act_e          act,
  input  logic               order_mode,
  input  logic [BURST_W-1:0] start_in,
  output logic [BURST_W-1:0] low_next
);
  logic [BURST_W-1:0] start_q, start_d;
  logic [BURST_W-1:0] beat_q, beat_d;

  always_comb begin
    start_d = start_q;
    beat_d  = beat_q;
    case (act)
      ACT_LOAD: begin
        start_d = start_in;
        beat_d  = '0;
      end
      ACT_STEP: beat_d = beat_q + 1'b1;
      default: ;
    endcase
    // linear adds the beat index, interleaved xors it
    low_next = order_mode ? (start_d ^ beat_d) : (start_d + beat_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      start_q <= start_d;
      beat_q  <= beat_d;
    end
  end
endmodule

// File: rtl/sbag_top.sv
module sbag_top
  import sbag_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              advance_n,
  input  logic              order_mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  sbag_act_e          act;
  logic [BURST_W-1:0] low_next;
  logic [UPPER_W-1:0] upper_next;
  logic [ADDR_W-1:0]  addr_q;
  logic               valid_q;

  sbag_arbiter u_arb (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .sel_n         (sel_n),
    .sel_hi        (sel_hi),
    .sel_lo_n      (sel_lo_n),
    .advance_n     (advance_n),
    .valid_q       (valid_q),
    .act           (act)
  );

  sbag_burst_seq #(.BURST_W(BURST_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .order_mode (order_mode),
    .start_in   (addr_in[BURST_W-1:0]),
    .low_next   (low_next)
  );

  always_comb begin
    upper_next = (act == ACT_LOAD) ? addr_in[ADDR_W-1:BURST_W]
                                   : addr_q[ADDR_W-1:BURST_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      addr_q <= {upper_next, low_next};
      if (act == ACT_LOAD)
        valid_q <= 1'b1;
      else if (act == ACT_DESEL)
        valid_q <= 1'b0;
    end
  end

  assign addr_out   = addr_q;
  assign addr_valid = valid_q;
endmodule

// File: rtl/sbag_checker.sv
module sbag_checker #(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              sel_n,
  input logic              sel_hi,
  input logic              sel_lo_n,
  input logic              advance_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_valid
);
  logic en_all;
  logic proc_hit;
  logic strobe_hit;
  assign en_all     = !sel_n && sel_hi && !sel_lo_n;
  assign proc_hit   = !proc_strobe_n && !sel_n;
  assign strobe_hit = proc_hit || !ctrl_strobe_n;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !addr_valid && addr_out == '0);

  assert_proc_load_R2: assert property (@(posedge clk) disable iff (rst)
    (proc_hit && en_all) |=> addr_valid && addr_out == $past(addr_in));

  assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_strobe_n && proc_strobe_n && en_all) |=> addr_valid && addr_out == $past(addr_in));

  assert_deselect_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe_hit && !en_all) |=> !addr_valid && $stable(addr_out));

  assert_idle_stays_invalid_R5: assert property (@(posedge clk) disable iff (rst)
    (!strobe_hit && !addr_valid) |=> !addr_valid && $stable(addr_out));

  assert_suspend_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!strobe_hit && advance_n) |=> $stable(addr_out) && $stable(addr_valid));

  assert_upper_fixed_R13: assert property (@(posedge clk) disable iff (rst)
    !strobe_hit |=> $stable(addr_out[ADDR_W-1:BURST_W]));
endmodule

bind sbag_top sbag_checker #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .proc_strobe_n (proc_strobe_n),
  .ctrl_strobe_n (ctrl_strobe_n),
  .sel_n         (sel_n),
  .sel_hi        (sel_hi),
  .sel_lo_n      (sel_lo_n),
  .advance_n     (advance_n),
  .addr_in       (addr_in),
  .addr_out      (addr_out),
  .addr_valid    (addr_valid)
);

// File: tb/sbag_top_bench.sv
module sbag_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1;
  logic sel_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic advance_n = 1'b1, order_mode = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic addr_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_upper = 0, m_start = 0, m_beat = 0, m_addr = 0;
  bit m_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbag_top #(.ADDR_W(AW), .BURST_W(BW)) u_sbag_top (
    .clk(clk), .rst(rst), .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .advance_n(advance_n),
    .order_mode(order_mode), .addr_in(addr_in), .addr_out(addr_out), .addr_valid(addr_valid)
  );

  task automatic model_edge();
    bit proc_ok, strobe, enabled;
    int low;
    if (rst) begin
      m_valid = 0; m_upper = 0; m_start = 0; m_beat = 0; m_addr = 0;
      return;
    end
    proc_ok = !proc_strobe_n && !sel_n;
    strobe  = proc_ok || !ctrl_strobe_n;
    enabled = !sel_n && sel_hi && !sel_lo_n;
    if (strobe && enabled) begin
      m_upper = int'(addr_in) / 4; m_start = int'(addr_in) % 4; m_beat = 0; m_valid = 1;
    end else if (strobe) begin
      m_valid = 0;
    end else if (m_valid && !advance_n) begin
      m_beat = (m_beat + 1) % 4;
    end
    if (order_mode) low = m_start ^ m_beat;
    else low = (m_start + m_beat) % 4;
    if (!(strobe && !enabled) && !(!strobe && !m_valid)) m_addr = m_upper * 4 + low;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (addr_valid !== m_valid || int'(addr_out) !== m_addr) begin
      errors++;
      $display("FAIL %s: actual addr=%0h valid=%0b expected addr=%0h valid=%0b",
               tag, addr_out, addr_valid, m_addr, m_valid);
    end
  endtask

  task automatic cyc(input bit p, input bit c, input bit sn, input bit sh, input bit sl,
                     input bit adv, input bit mode, input int a, input string tag);
    proc_strobe_n = p; ctrl_strobe_n = c; sel_n = sn; sel_hi = sh; sel_lo_n = sl;
    advance_n = adv; order_mode = mode; addr_in = AW'(a);
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
  endtask

  // shorthands
  task automatic step(input bit mode, input string tag);
    cyc(1, 1, 0, 1, 0, 0, mode, 12'h000, tag);
  endtask
  task automatic pause(input bit mode, input string tag);
    cyc(1, 1, 0, 1, 0, 1, mode, 12'h000, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    rst = 1'b1;
    cyc(1, 1, 0, 1, 0, 1, 0, 0, "R1 reset");
    cyc(1, 1, 0, 1, 0, 0, 0, 0, "R1 reset held");
    rst = 1'b0;
    step(0, "R5 advance ignored before first load");
    step(0, "R5 still invalid");
    // linear burst from 01 via processor strobe
    cyc(0, 1, 0, 1, 0, 1, 0, 12'h5A1, "R2 processor load");
    step(0, "R7 linear beat 10");
    step(0, "R7 linear beat 11");
    pause(0, "R10 suspend");
    pause(0, "R10 suspend again");
    // enables toggled during continuation, no strobe
    cyc(1, 1, 1, 0, 1, 0, 0, 12'hFFF, "R11 enables ignored mid burst");
    step(0, "R9 linear wraps to start 01");
    step(0, "R13 upper bits unchanged");
    // interleaved burst from 10 via controller strobe
    cyc(1, 0, 0, 1, 0, 1, 1, 12'h3C6, "R3 controller load");
    step(1, "R8 interleaved beat 11");
    step(1, "R8 interleaved beat 00");
    step(1, "R8 interleaved beat 01");
    step(1, "R9 interleaved wraps to start 10");
    // both strobes together
    step(1, "R8 continue");
    cyc(0, 0, 0, 1, 0, 0, 1, 12'h7E3, "R4 both strobes single load");
    step(1, "R4 beat index restarted");
    // processor strobe with primary enable high is ignored
    cyc(0, 1, 1, 1, 0, 0, 1, 12'h111, "R6 proc ignored, advance acts");
    cyc(0, 1, 1, 1, 0, 1, 1, 12'h222, "R6 proc ignored, hold");
    // mid burst reload
    cyc(1, 0, 0, 1, 0, 0, 0, 12'h400, "R12 reload mid burst");
    step(0, "R12 new burst beat 01");
    step(0, "R12 new burst beat 10");
    // controller strobe while primary enable high deselects
    cyc(0, 0, 1, 1, 0, 0, 0, 12'h999, "R6 ctrl deselects with proc ignored");
    step(0, "R5 advance no effect while deselected");
    cyc(0, 1, 0, 1, 0, 1, 0, 12'h0AB, "R2 reload after deselect");
    cyc(0, 1, 0, 0, 0, 1, 0, 12'h0CD, "R5 deselect by sel_hi low");
    cyc(1, 0, 0, 1, 0, 1, 0, 12'h0EF, "R3 reload");
    cyc(1, 0, 0, 1, 1, 1, 0, 12'h111, "R5 deselect by sel_lo_n high");
    step(0, "R5 advance no effect after deselect");
    // carry out of burst bits never reaches upper bits
    cyc(0, 1, 0, 1, 0, 1, 0, 12'h5FF, "R2 load at 11");
    step(0, "R13 wrap to 00 keeps upper");
    step(0, "R7 linear 01");
    rst = 1'b1;
    cyc(1, 1, 0, 1, 0, 1, 0, 0, "R1 reset mid run");
    rst = 1'b0;
    pause(0, "R1 stays cleared");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule